// File: doc/BRIEF.md
# Up/Down Event Counter with Snapshot Register

This block keeps a 32-bit signed-agnostic running count of events and exposes it on a parallel output. The events come from one of three sources, picked by a source-select input: a count-clock pin paired with a direction pin, a two-phase quadrature pair on those same two pins, or a free-running internal tick derived from the system clock. Four level controls steer the count: load forces a host-supplied value, clear forces zero, enable gates counting, and latch copies the running count into a snapshot register. A wide count that moves while software reads it word by word can tear, so the snapshot gives a coherent value to read.

All six asynchronous pins pass through two-flop synchronisers. Edge detection happens in the system clock domain. A mode input turns enable from a plain level gate into a sticky run flag. In sticky mode, a rising edge on enable sets the flag and only clear drops it. The count wraps modulo 2^32 in both directions.

Top module: `evt_counter`

## Requirements
- R1: With source select 2'b00, each rising edge of `cnt_clk_i` changes the count by +1 when `cnt_dir_i` is high and by -1 when it is low. Pin changes reach the count on the third rising system clock edge after they are applied.
- R2: With source select 2'b01, the pair {`cnt_clk_i`,`cnt_dir_i`} is a quadrature state. The sequence 00→10→11→01→00 counts +1 per step, and the reverse sequence counts -1 per step. A change of both bits at once leaves the count unchanged.
- R3: With source select 2'b10, the count rises by exactly one every TICK_DIV system clocks (default 5) while counting is enabled. With source select 2'b11, no event source is connected and the count holds.
- R4: While load is high, the count equals `load_value_i` and ignores events. After load falls, counting resumes from that value.
- R5: While clear is high, the count is zero, even when load is also high. Zero appears on the third rising clock edge after clear is applied.
- R6: A rising edge of latch copies the running count into `latch_o` without disturbing counting. `latch_o` keeps that value while latch stays high and until the next rising edge of latch.
- R7: With `sticky_mode_i` low, events count only while enable is high.
- R8: With `sticky_mode_i` high, a rising edge of enable starts counting and counting continues after enable falls. Clear zeroes the count and stops counting until enable rises again.
- R9: Counting up from 32'hFFFFFFFF gives 0. Counting down from 0 gives 32'hFFFFFFFF.
- R10: After reset, both `count_o` and `latch_o` are zero and the sticky run flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 2 | Event source: 00 clock/direction, 01 quadrature, 10 internal tick, 11 none |
| sticky_mode_i | input | 1 | 1 selects the sticky enable behaviour |
| cnt_clk_i | input | 1 | Count clock, or quadrature channel A |
| cnt_dir_i | input | 1 | Direction, or quadrature channel B |
| load_i | input | 1 | Hold the count at the load value |
| enable_i | input | 1 | Count enable (level, or rising-edge set in sticky mode) |
| clear_i | input | 1 | Hold the count at zero |
| latch_i | input | 1 | Rising edge captures a snapshot |
| load_value_i | input | 32 | Value forced while load is high |
| count_o | output | 32 | Running count |
| latch_o | output | 32 | Snapshot of the count |

## Verification
Each pin change passes through two synchroniser flops, and then the count or snapshot register is updated. So any effect of a pin shows on the third rising edge after it is applied. A sticky-mode start needs one more edge because the run flag is set first. The bench drives pins on the falling edge and, for the clear and count-clock cases, samples two falling edges later to confirm the old value is still there, then one edge later to confirm the new one. Every other check waits four clocks after its stimulus, which is past every stage. The tick-rate check compares two samples taken fifty clocks apart, which spans exactly ten divider periods.

// File: rtl/evt_counter_pkg.sv
package evt_counter_pkg;

  typedef enum logic [1:0] {
    SRC_CLKDIR = 2'b00,
    SRC_QUAD   = 2'b01,
    SRC_TICK   = 2'b10,
    SRC_NONE   = 2'b11
  } evt_src_e;

  typedef struct packed {
    logic valid;
    logic up;
  } evt_step_t;

  // index of each pin inside the synchroniser vector
  localparam int unsigned PIN_A     = 0;
  localparam int unsigned PIN_B     = 1;
  localparam int unsigned PIN_LOAD  = 2;
  localparam int unsigned PIN_EN    = 3;
  localparam int unsigned PIN_CLR   = 4;
  localparam int unsigned PIN_LATCH = 5;
  localparam int unsigned PIN_COUNT = 6;

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_i;
      end else begin : g_rest
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/evt_step_gen.sv
module evt_step_gen
  import evt_counter_pkg::*;
#(
  parameter int unsigned TICK_DIV = 5
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  evt_src_e  src_i,
  input  logic      a_i,
  input  logic      b_i,
  output evt_step_t step_o
);

  localparam int unsigned DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic             a_q, b_q;
  logic [DIV_W-1:0] div_q, div_d;
  logic             tick;
  evt_step_t        cd_step, quad_step;

  // free-running internal tick divider
  always_comb begin
    tick  = (div_q == DIV_LAST);
    div_d = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      div_q <= '0;
    end else begin
      a_q   <= a_i;
      b_q   <= b_i;
      div_q <= div_d;
    end
  end

  // clock/direction: one step per rising edge of A, B gives the sense
  always_comb begin
    cd_step.valid = a_i & ~a_q;
    cd_step.up    = b_i;
  end

  // quadrature x4: forward order 00 -> 10 -> 11 -> 01 -> 00 on {A,B}
  always_comb begin
    quad_step = '0;
    unique case ({a_q, b_q, a_i, b_i})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: begin
        quad_step.valid = 1'b1;
        quad_step.up    = 1'b1;
      end
      4'b1000, 4'b1110, 4'b0111, 4'b0001: begin
        quad_step.valid = 1'b1;
        quad_step.up    = 1'b0;
      end
      default: quad_step = '0;
    endcase
  end

  always_comb begin
    unique case (src_i)
      SRC_CLKDIR: step_o = cd_step;
      SRC_QUAD:   step_o = quad_step;
      SRC_TICK:   step_o = '{valid: tick, up: 1'b1};
      default:    step_o = '0;
    endcase
  end

endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sticky_i,
  input  logic en_i,
  input  logic clr_i,
  input  logic latch_i,
  output logic run_o,
  output logic latch_rise_o
);

  logic en_q, lat_q, flag_q, flag_d, en_rise;

  always_comb begin
    en_rise      = en_i & ~en_q;
    latch_rise_o = latch_i & ~lat_q;
    if (clr_i)        flag_d = 1'b0;
    else if (en_rise) flag_d = 1'b1;
    else              flag_d = flag_q;
    run_o = sticky_i ? flag_q : en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lat_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_i;
      lat_q  <= latch_i;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/evt_accum.sv
module evt_accum
  import evt_counter_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  evt_step_t        step_i,
  input  logic             run_i,
  input  logic             ld_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] load_value_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // priority: clear, then load, then counting
  always_comb begin
    cnt_en = clr_i | ld_i | (run_i & step_i.valid);
    if (clr_i)            cnt_d = '0;
    else if (ld_i)        cnt_d = load_value_i;
    else if (step_i.up)   cnt_d = cnt_q + 1'b1;
    else                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evt_counter_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned TICK_DIV = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       src_sel_i,
  input  logic             sticky_mode_i,
  input  logic             cnt_clk_i,
  input  logic             cnt_dir_i,
  input  logic             load_i,
  input  logic             enable_i,
  input  logic             clear_i,
  input  logic             latch_i,
  input  logic [CNT_W-1:0] load_value_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] latch_o
);

  logic [PIN_COUNT-1:0] pins_raw, pins_s;
  logic                 a_s, b_s, ld_s, en_s, clr_s, lat_s;
  logic                 run, latch_rise;
  evt_step_t            step;
  logic [CNT_W-1:0]     snap_q, snap_d;

  always_comb begin
    pins_raw            = '0;
    pins_raw[PIN_A]     = cnt_clk_i;
    pins_raw[PIN_B]     = cnt_dir_i;
    pins_raw[PIN_LOAD]  = load_i;
    pins_raw[PIN_EN]    = enable_i;
    pins_raw[PIN_CLR]   = clear_i;
    pins_raw[PIN_LATCH] = latch_i;
  end

  evt_sync #(.WIDTH(PIN_COUNT), .STAGES(2)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pins_raw),
    .sync_o (pins_s)
  );

  assign a_s   = pins_s[PIN_A];
  assign b_s   = pins_s[PIN_B];
  assign ld_s  = pins_s[PIN_LOAD];
  assign en_s  = pins_s[PIN_EN];
  assign clr_s = pins_s[PIN_CLR];
  assign lat_s = pins_s[PIN_LATCH];

  evt_step_gen #(.TICK_DIV(TICK_DIV)) step_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (evt_src_e'(src_sel_i)),
    .a_i   (a_s),
    .b_i   (b_s),
    .step_o(step)
  );

  evt_ctrl ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sticky_i    (sticky_mode_i),
    .en_i        (en_s),
    .clr_i       (clr_s),
    .latch_i     (lat_s),
    .run_o       (run),
    .latch_rise_o(latch_rise)
  );

  evt_accum #(.CNT_W(CNT_W)) accum_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .run_i       (run),
    .ld_i        (ld_s),
    .clr_i       (clr_s),
    .load_value_i(load_value_i),
    .count_o     (count_o)
  );

  // snapshot register: captures on the latch rising edge only
  always_comb snap_d = count_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         snap_q <= '0;
    else if (latch_rise) snap_q <= snap_d;
  end

  assign latch_o = snap_q;

endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sticky_mode_i,
  input logic             ld_s,
  input logic             en_s,
  input logic             clr_s,
  input logic             latch_rise,
  input logic             run,
  input logic [CNT_W-1:0] load_value_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] latch_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_s |=> (count_o == '0)); // R5

  AST_LOAD_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_s && !clr_s) |=> (count_o == $past(load_value_i))); // R4

  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_s && !clr_s) |=> (count_o == $past(count_o) ||
                           count_o == $past(count_o) + ONE ||
                           count_o == $past(count_o) - ONE)); // R9

  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_rise |=> $stable(latch_o)); // R6

  AST_SNAP_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_rise |=> (latch_o == $past(count_o))); // R6

  AST_PLAIN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sticky_mode_i && !en_s && !ld_s && !clr_s) |=> $stable(count_o)); // R7

  AST_STICKY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_mode_i && clr_s) |=> !run); // R8

endmodule

bind evt_counter evt_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sticky_mode_i(sticky_mode_i),
  .ld_s         (ld_s),
  .en_s         (en_s),
  .clr_s        (clr_s),
  .latch_rise   (latch_rise),
  .run          (run),
  .load_value_i (load_value_i),
  .count_o      (count_o),
  .latch_o      (latch_o)
);

// File: tb/evt_counter_tb.sv
module evt_counter_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [1:0]  src_sel_i;
  logic        sticky_mode_i, cnt_clk_i, cnt_dir_i;
  logic        load_i, enable_i, clear_i, latch_i;
  logic [31:0] load_value_i, count_o, latch_o;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;
  logic [31:0] exp_cnt;
  logic [1:0]  qstate;

  always #10 clk_i = ~clk_i;

  evt_counter dut_i (
    .clk_i, .rst_ni, .src_sel_i, .sticky_mode_i, .cnt_clk_i, .cnt_dir_i,
    .load_i, .enable_i, .clear_i, .latch_i, .load_value_i, .count_o, .latch_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic pulse_cd(input bit up);
    cnt_dir_i = up; settle();
    cnt_clk_i = 1'b1; settle();
    cnt_clk_i = 1'b0; settle();
  endtask

  task automatic pulse_clear();
    clear_i = 1'b1; settle();
    clear_i = 1'b0; settle();
  endtask

  // expected quadrature step from the R2 sequence 00->10->11->01->00
  function automatic int qdelta(input logic [1:0] p, input logic [1:0] c);
    if ((p == 2'b00 && c == 2'b10) || (p == 2'b10 && c == 2'b11) ||
        (p == 2'b11 && c == 2'b01) || (p == 2'b01 && c == 2'b00)) return 1;
    if ((c == 2'b00 && p == 2'b10) || (c == 2'b10 && p == 2'b11) ||
        (c == 2'b11 && p == 2'b01) || (c == 2'b01 && p == 2'b00)) return -1;
    return 0;
  endfunction

  task automatic quad_to(input logic [1:0] ab);
    exp_cnt = exp_cnt + 32'(qdelta(qstate, ab));
    qstate  = ab;
    {cnt_clk_i, cnt_dir_i} = ab;
    settle();
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] c0, c1, snap;
    void'($urandom(32'h5EED_0042));
    rst_ni = 1'b0; src_sel_i = 2'b00; sticky_mode_i = 1'b0;
    cnt_clk_i = 0; cnt_dir_i = 0; load_i = 0; enable_i = 0;
    clear_i = 0; latch_i = 0; load_value_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 count after reset", count_o, 32'h0);
    chk("R10 snapshot after reset", latch_o, 32'h0);

    // R1: latency and direction
    enable_i = 1'b1; cnt_dir_i = 1'b1; settle();
    cnt_clk_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 not yet counted after two edges", count_o, 32'h0);
    @(negedge clk_i);
    chk("R1 counted on third edge", count_o, 32'h1);
    cnt_clk_i = 1'b0; settle();
    pulse_cd(1'b1); pulse_cd(1'b1); pulse_cd(1'b0);
    chk("R1 up/up/down", count_o, 32'h2);

    // R4 and R9
    load_value_i = 32'hFFFF_FFFF; load_i = 1'b1; settle();
    chk("R4 load forces value", count_o, 32'hFFFF_FFFF);
    pulse_cd(1'b0);
    chk("R4 events ignored during load", count_o, 32'hFFFF_FFFF);
    load_i = 1'b0; settle();
    pulse_cd(1'b1);
    chk("R9 wrap up to zero", count_o, 32'h0);
    pulse_cd(1'b0);
    chk("R9 wrap down to all ones", count_o, 32'hFFFF_FFFF);

    // R5: priority and latency
    load_value_i = 32'h0000_1234; load_i = 1'b1; clear_i = 1'b1; settle();
    chk("R5 clear beats load", count_o, 32'h0);
    clear_i = 1'b0; settle();
    chk("R4 load after clear released", count_o, 32'h0000_1234);
    load_i = 1'b0; settle();
    clear_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R5 old value two edges after clear", count_o, 32'h0000_1234);
    @(negedge clk_i);
    chk("R5 zero on third edge", count_o, 32'h0);
    pulse_cd(1'b1);
    chk("R5 held at zero", count_o, 32'h0);
    clear_i = 1'b0; settle();

    // R6 snapshot
    pulse_cd(1'b1); pulse_cd(1'b1); pulse_cd(1'b1);
    latch_i = 1'b1; settle();
    chk("R6 capture on rising latch", latch_o, 32'h3);
    pulse_cd(1'b1);
    chk("R6 counting undisturbed", count_o, 32'h4);
    chk("R6 no recapture while held", latch_o, 32'h3);
    latch_i = 1'b0; settle();
    pulse_cd(1'b1);
    chk("R6 holds after fall", latch_o, 32'h3);
    latch_i = 1'b1; settle(); latch_i = 1'b0; settle();
    chk("R6 next capture", latch_o, 32'h5);

    // R7 plain enable
    enable_i = 1'b0; settle();
    pulse_cd(1'b1); pulse_cd(1'b0); pulse_cd(1'b1);
    chk("R7 no count while disabled", count_o, 32'h5);
    enable_i = 1'b1; settle();
    pulse_cd(1'b1);
    chk("R7 count when enabled", count_o, 32'h6);

    // R8 sticky
    enable_i = 1'b0; sticky_mode_i = 1'b1; settle();
    pulse_clear();
    pulse_cd(1'b1);
    chk("R8 idle before enable edge", count_o, 32'h0);
    enable_i = 1'b1; settle(); enable_i = 1'b0; settle();
    pulse_cd(1'b1); pulse_cd(1'b1);
    chk("R8 counts after enable falls", count_o, 32'h2);
    pulse_clear();
    chk("R8 clear zeroes", count_o, 32'h0);
    pulse_cd(1'b1);
    chk("R8 clear drops run flag", count_o, 32'h0);
    enable_i = 1'b1; settle();
    pulse_cd(1'b0);
    chk("R8 restart on new edge", count_o, 32'hFFFF_FFFF);
    enable_i = 1'b0; sticky_mode_i = 1'b0; settle();

    // R2 quadrature
    enable_i = 1'b1; cnt_clk_i = 0; cnt_dir_i = 0; settle();
    pulse_clear();
    src_sel_i = 2'b01; qstate = 2'b00; exp_cnt = '0; settle();
    quad_to(2'b10); quad_to(2'b11); quad_to(2'b01); quad_to(2'b00);
    chk("R2 forward cycle", count_o, 32'h4);
    quad_to(2'b01); quad_to(2'b11);
    chk("R2 reverse steps", count_o, 32'h2);
    quad_to(2'b00);
    chk("R2 double jump ignored", count_o, 32'h2);
    for (int i = 0; i < 120; i++) begin
      quad_to(2'($urandom));
      chk("R2 random quadrature", count_o, exp_cnt);
    end
    quad_to(2'b00); settle();

    // R3 internal tick and empty source
    src_sel_i = 2'b10; pulse_clear();
    c0 = count_o; repeat (50) @(negedge clk_i); c1 = count_o;
    chk("R3 ten ticks in fifty clocks", c1 - c0, 32'd10);
    enable_i = 1'b0; settle();
    c0 = count_o; repeat (50) @(negedge clk_i);
    chk("R7 tick gated by enable", count_o, c0);
    src_sel_i = 2'b11; enable_i = 1'b1; settle();
    c0 = count_o; pulse_cd(1'b1); repeat (20) @(negedge clk_i);
    chk("R3 no source holds", count_o, c0);

    // random clock/direction with enable and snapshot
    src_sel_i = 2'b00; pulse_clear(); exp_cnt = '0;
    for (int i = 0; i < 150; i++) begin
      int unsigned op;
      bit up;
      op = $urandom % 8;
      up = 1'($urandom);
      if (op < 5) begin
        enable_i = (op != 0); settle();
        pulse_cd(up);
        if (enable_i) exp_cnt = up ? exp_cnt + 1 : exp_cnt - 1;
        chk("R1 random clock/direction", count_o, exp_cnt);
      end else if (op == 5) begin
        latch_i = 1'b1; settle(); latch_i = 1'b0; settle();
        snap = exp_cnt;
        chk("R6 random snapshot", latch_o, snap);
      end else begin
        load_value_i = $urandom; load_i = 1'b1; settle();
        load_i = 1'b0; settle();
        exp_cnt = load_value_i;
        chk("R4 random load", count_o, exp_cnt);
      end
    end

    done = 1'b1;
    report();
  end

endmodule